// File: doc/BRIEF.md
# PLL Retune Sequencer

This block is the control state machine that moves a PLL from one set of divider ratios to another without glitching its consumers. A single start pulse launches a fixed run: the block notes whether the clock output mux is currently passing the PLL output, and if so parks it on the slow reference. It then frames the divider update with a PLL reset, writes the four divider ratios, waits a settle time sized from the reference ratio, and polls the lock flag for a bounded number of cycles. If lock never arrives, the ratios read back at the start are written again and a second lock wait follows. The run ends by handing the mux back to the PLL output if, and only if, the block took it away.

The requester sees `busy_o` for the whole run, a one-cycle `done_o` at the end, and an `err_o` flag that remains set until the next run is accepted. The analog PLL, its divider register file and the output mux register live outside. The block reads their current values and drives write strobes towards them. The parameter `RESET_STYLE` selects whether the reset framing and the settle wait are used.

Top module: `pll_retune_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `busy_o`, `done_o`, `err_o`, `div_wr_o`, `mode_wr_o` and `pll_rst_o` are all 0.
- R2: `start_i` is accepted only when `busy_o` is 0. An accepted start produces its first divider write three cycles later. Start pulses seen while busy cause no further divider write and no further `done_o`.
- R3: Mode encoding is 0 for slow reference, 1 for normal (PLL output) and 2 for deep-slow. If `mode_i` is 1 when the start is accepted, the block writes mode 0 before the first divider write, and writes mode 1 in the cycle just before `done_o`. For any other mode it makes no mode write.
- R4: With `RESET_STYLE` set, `pll_rst_o` rises in the cycle before each divider write, is high during the write, and is low again in the cycle after it.
- R5: After a divider write with reference ratio r, lock is not sampled for N = ((r*500)/24 + 1) * `CYC_PER_US` cycles. With `lock_i` already high, `done_o` comes exactly N+3 cycles after the write cycle.
- R6: Lock is sampled in every polling cycle. Two cycles after the first polling cycle with `lock_i` high, `done_o` is asserted with `err_o` 0.
- R7: After `LOCK_POLLS` polling cycles without lock, `err_o` is set and the ratios sampled on the `cur_*` inputs at start are written back, N+`LOCK_POLLS`+2 cycles after the first write. A full reset, settle and lock wait follow, and `done_o` is still given with `err_o` 1.
- R8: `err_o` holds its value while idle and is cleared in the cycle after the next accepted start.
- R9: A request whose ratios equal the current ones runs the complete sequence, including the divider write and reset framing.
- R10: The ratios written are those present on the request inputs in the start cycle. Later changes on those inputs have no effect.
- R11: `done_o` is high for exactly one cycle per accepted run.
- R12: If the lock wait after the write-back also times out, the run ends with no third write, `done_o` comes N_old+`LOCK_POLLS`+2 cycles after the second write, and `err_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse to retune |
| ref_div_i | input | REF_W | Requested reference ratio |
| out_div_i | input | OUT_W | Requested output ratio |
| fb_div_i | input | FB_W | Requested feedback ratio |
| bw_div_i | input | BW_W | Requested bandwidth ratio |
| cur_ref_i | input | REF_W | Reference ratio now in the PLL |
| cur_out_i | input | OUT_W | Output ratio now in the PLL |
| cur_fb_i | input | FB_W | Feedback ratio now in the PLL |
| cur_bw_i | input | BW_W | Bandwidth ratio now in the PLL |
| mode_i | input | 2 | Current output mux mode |
| mode_wr_o | output | 1 | Mux mode write strobe |
| mode_sel_o | output | 2 | Mux mode value to write |
| pll_rst_o | output | 1 | PLL reset |
| div_wr_o | output | 1 | Divider write strobe |
| ref_div_o | output | REF_W | Reference ratio to write |
| out_div_o | output | OUT_W | Output ratio to write |
| fb_div_o | output | FB_W | Feedback ratio to write |
| bw_div_o | output | BW_W | Bandwidth ratio to write |
| lock_i | input | 1 | PLL lock flag |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Sticky lock-timeout flag |

## Verification
The bench models the PLL as a register file whose lock flag rises a chosen number of cycles after a write, and never rises for a zero feedback ratio. This exposes a design that polls during the settle time (its done would come early), miscounts the poll limit (its write-back would land off by a cycle), or writes back the new ratios instead of the captured ones. Runs that start in slow or deep-slow mode catch a design that always restores normal mode. A run whose write-back also fails catches a design that loops into a third write or clears the error. Extra start pulses mid-run and input changes after the start cycle catch a design that restarts or fails to latch its request.

// File: rtl/pll_seq_pkg.sv
// Shared definitions for the PLL retune sequencer: FSM states, mux mode
// codes and the settle-time rule. Assumes nothing beyond 32-bit arithmetic.
package pll_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BYPASS,
        ST_RST,
        ST_LOAD,
        ST_SETTLE,
        ST_POLL,
        ST_RESUME,
        ST_DONE
    } seq_state_t;

    localparam logic [1:0] MODE_SLOW   = 2'd0;
    localparam logic [1:0] MODE_NORMAL = 2'd1;
    localparam logic [1:0] MODE_DEEP   = 2'd2;

    // Settle time in microseconds after reset release for a reference ratio.
    function automatic int unsigned settle_us(input int unsigned ref_ratio);
        return (ref_ratio * 500) / 24 + 1;
    endfunction

endpackage

// File: rtl/pll_seq_settle.sv
// Down-counter for the post-reset settle wait.
// Loads a cycle count and reports the last cycle of the wait (count == 1).
// Assumes the loaded value is at least 1.
module pll_seq_settle #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pll_seq_lock_watch.sv
// Lock poller with a bounded number of polls.
// While polling is high, each cycle samples lock; after LIMIT samples without
// lock it flags a timeout. The count clears whenever polling is low.
module pll_seq_lock_watch #(
    parameter int unsigned LIMIT = 24000000,
    parameter int unsigned CNT_W = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic polling,
    input  logic lock_i,
    output logic locked,
    output logic timeout
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == CNT_W'(LIMIT - 1));

    // Count failed polls; restart the count outside a polling window.
    always_ff @(posedge clk) begin
        if (!rst_n || !polling) begin
            cnt_q <= '0;
        end else if (!lock_i && !at_limit) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign locked  = polling && lock_i;
    assign timeout = polling && !lock_i && at_limit;

endmodule

// File: rtl/pll_seq_div_bank.sv
// Holds the requested and the prior divider ratios of one run.
// Both are captured together at start; the output picks prior or requested.
module pll_seq_div_bank #(
    parameter int unsigned W = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         use_old,
    input  logic [W-1:0] new_i,
    input  logic [W-1:0] old_i,
    output logic [W-1:0] sel_o
);

    logic [W-1:0] new_q;
    logic [W-1:0] old_q;

    // Snapshot both ratio sets when a run is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_q <= '0;
            old_q <= '0;
        end else if (capture) begin
            new_q <= new_i;
            old_q <= old_i;
        end
    end

    assign sel_o = use_old ? old_q : new_q;

endmodule

// File: rtl/pll_retune_seq.sv
// PLL retune sequencer top.
// On an accepted start: park the mux on the slow reference if it was normal,
// frame the divider write with PLL reset (RESET_STYLE), wait the settle time,
// poll lock with a bound, write back the prior ratios once on timeout, then
// return the mux to normal if it was moved. Assumes the mux and divider
// registers are written outside from the strobes given here.
module pll_retune_seq #(
    parameter int unsigned REF_W       = 6,
    parameter int unsigned OUT_W       = 4,
    parameter int unsigned FB_W        = 13,
    parameter int unsigned BW_W        = 12,
    parameter int unsigned CYC_PER_US  = 24,
    parameter int unsigned LOCK_POLLS  = 24000000,
    parameter int unsigned RESET_STYLE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [REF_W-1:0] ref_div_i,
    input  logic [OUT_W-1:0] out_div_i,
    input  logic [FB_W-1:0]  fb_div_i,
    input  logic [BW_W-1:0]  bw_div_i,
    input  logic [REF_W-1:0] cur_ref_i,
    input  logic [OUT_W-1:0] cur_out_i,
    input  logic [FB_W-1:0]  cur_fb_i,
    input  logic [BW_W-1:0]  cur_bw_i,
    input  logic [1:0]       mode_i,
    output logic             mode_wr_o,
    output logic [1:0]       mode_sel_o,
    output logic             pll_rst_o,
    output logic             div_wr_o,
    output logic [REF_W-1:0] ref_div_o,
    output logic [OUT_W-1:0] out_div_o,
    output logic [FB_W-1:0]  fb_div_o,
    output logic [BW_W-1:0]  bw_div_o,
    input  logic             lock_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);

    import pll_seq_pkg::*;

    localparam int unsigned DIV_W      = REF_W + OUT_W + FB_W + BW_W;
    localparam int unsigned SETTLE_MAX = settle_us((1 << REF_W) - 1) * CYC_PER_US;
    localparam int unsigned SETTLE_W   = $clog2(SETTLE_MAX + 1);
    localparam int unsigned POLL_W     = $clog2(LOCK_POLLS + 1);
    localparam bit          USE_RST    = (RESET_STYLE != 0);
    localparam seq_state_t  AFTER_BYP  = USE_RST ? ST_RST : ST_LOAD;
    localparam seq_state_t  AFTER_LOAD = USE_RST ? ST_SETTLE : ST_POLL;

    seq_state_t           state_q, state_d;
    logic                 remux_q;
    logic                 restore_q;
    logic                 err_q;
    logic                 accept;
    logic                 settle_done;
    logic                 locked;
    logic                 timeout;
    logic [DIV_W-1:0]     div_bus;
    logic [SETTLE_W-1:0]  settle_cycles;

    assign accept = (state_q == ST_IDLE) && start_i;

    pll_seq_div_bank #(.W(DIV_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .use_old (restore_q),
        .new_i   ({ref_div_i, out_div_i, fb_div_i, bw_div_i}),
        .old_i   ({cur_ref_i, cur_out_i, cur_fb_i, cur_bw_i}),
        .sel_o   (div_bus)
    );

    assign {ref_div_o, out_div_o, fb_div_o, bw_div_o} = div_bus;

    // Settle length derived from the reference ratio being written.
    always_comb begin
        settle_cycles = SETTLE_W'(settle_us(32'(ref_div_o)) * CYC_PER_US);
    end

    pll_seq_settle #(.CNT_W(SETTLE_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_LOAD),
        .load_val (settle_cycles),
        .expire   (settle_done)
    );

    pll_seq_lock_watch #(.LIMIT(LOCK_POLLS), .CNT_W(POLL_W)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .polling (state_q == ST_POLL),
        .lock_i  (lock_i),
        .locked  (locked),
        .timeout (timeout)
    );

    // Next-state selection for the retune run.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_BYPASS;
            ST_BYPASS: state_d = AFTER_BYP;
            ST_RST:    state_d = ST_LOAD;
            ST_LOAD:   state_d = AFTER_LOAD;
            ST_SETTLE: if (settle_done) state_d = ST_POLL;
            ST_POLL: begin
                if (locked) begin
                    state_d = ST_RESUME;
                end else if (timeout) begin
                    state_d = restore_q ? ST_RESUME : AFTER_BYP;
                end
            end
            ST_RESUME: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and per-run flags (mux moved, restoring, error).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            remux_q   <= 1'b0;
            restore_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                remux_q   <= (mode_i == MODE_NORMAL);
                restore_q <= 1'b0;
                err_q     <= 1'b0;
            end else if (timeout) begin
                err_q     <= 1'b1;
                restore_q <= 1'b1;
            end
        end
    end

    // Mux writes: slow on entry, normal on exit, only when the run moved it.
    always_comb begin
        mode_wr_o  = remux_q && ((state_q == ST_BYPASS) || (state_q == ST_RESUME));
        mode_sel_o = (state_q == ST_RESUME) ? MODE_NORMAL : MODE_SLOW;
    end

    generate
        if (USE_RST) begin : g_rst_frame
            assign pll_rst_o = (state_q == ST_RST) || (state_q == ST_LOAD);
        end else begin : g_no_rst
            assign pll_rst_o = 1'b0;
        end
    endgenerate

    assign div_wr_o = (state_q == ST_LOAD);
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = (state_q == ST_DONE);
    assign err_o    = err_q;

endmodule

// File: rtl/pll_retune_seq_chk.sv
// Property checker for the PLL retune sequencer, bound to the top module.
// Observes ports only; assumes synchronous active-low reset.
module pll_retune_seq_chk #(
    parameter int unsigned RESET_STYLE = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       mode_wr_o,
    input logic [1:0] mode_sel_o,
    input logic       pll_rst_o,
    input logic       div_wr_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o
);

    import pll_seq_pkg::*;

    localparam bit FRAMED = (RESET_STYLE != 0);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_write_framed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (FRAMED && div_wr_o) |-> pll_rst_o);

    assert_reset_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst_o) |-> $past(div_wr_o));

    assert_mode_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_o |-> (mode_sel_o != MODE_DEEP));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(div_wr_o || mode_wr_o || pll_rst_o || done_o));

    assert_err_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> busy_o);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(err_o));

    assert_done_unreset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pll_rst_o);

endmodule

bind pll_retune_seq pll_retune_seq_chk #(.RESET_STYLE(RESET_STYLE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_wr_o  (mode_wr_o),
    .mode_sel_o (mode_sel_o),
    .pll_rst_o  (pll_rst_o),
    .div_wr_o   (div_wr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/pll_retune_seq_test.sv
module pll_retune_seq_test;

    localparam int REF_W = 6;
    localparam int OUT_W = 4;
    localparam int FB_W  = 13;
    localparam int BW_W  = 12;
    localparam int CPU   = 1;
    localparam int POLLS = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [REF_W-1:0] ref_div_i = '0, cur_ref_i, ref_div_o;
    logic [OUT_W-1:0] out_div_i = '0, cur_out_i, out_div_o;
    logic [FB_W-1:0]  fb_div_i  = '0, cur_fb_i,  fb_div_o;
    logic [BW_W-1:0]  bw_div_i  = '0, cur_bw_i,  bw_div_o;
    logic [1:0] mode_i, mode_sel_o;
    logic mode_wr_o, pll_rst_o, div_wr_o, lock_i, busy_o, done_o, err_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit wd_hit = 1'b0;

    // PLL and mux model
    logic [REF_W-1:0] m_ref = '0;
    logic [OUT_W-1:0] m_out = '0;
    logic [FB_W-1:0]  m_fb  = '0;
    logic [BW_W-1:0]  m_bw  = '0;
    logic [1:0]       m_mode = '0;
    int since_wr = 0;
    int lat = 0;
    bit preset_en = 1'b0;
    int p_ref, p_out, p_fb, p_bw, p_mode;

    // Monitor records
    int nw, nm, nd, nrr, nrf;
    int wr_cyc[4];
    logic [FB_W-1:0] wr_fb[4];
    logic [REF_W-1:0] wr_ref[4];
    logic [OUT_W-1:0] wr_out[4];
    logic [BW_W-1:0] wr_bw[4];
    bit wr_rst[4];
    int mw_cyc[4];
    int mw_val[4];
    int rr_cyc[4];
    int rf_cyc[4];
    int d_cyc;
    bit d_err;
    bit dw_bad;
    bit prev_rst = 1'b0;
    bit prev_done = 1'b0;

    assign cur_ref_i = m_ref;
    assign cur_out_i = m_out;
    assign cur_fb_i  = m_fb;
    assign cur_bw_i  = m_bw;
    assign mode_i    = m_mode;
    assign lock_i    = !pll_rst_o && (m_fb != '0) && (since_wr >= lat);

    pll_retune_seq #(
        .REF_W(REF_W), .OUT_W(OUT_W), .FB_W(FB_W), .BW_W(BW_W),
        .CYC_PER_US(CPU), .LOCK_POLLS(POLLS), .RESET_STYLE(1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ref_div_i(ref_div_i), .out_div_i(out_div_i), .fb_div_i(fb_div_i), .bw_div_i(bw_div_i),
        .cur_ref_i(cur_ref_i), .cur_out_i(cur_out_i), .cur_fb_i(cur_fb_i), .cur_bw_i(cur_bw_i),
        .mode_i(mode_i), .mode_wr_o(mode_wr_o), .mode_sel_o(mode_sel_o),
        .pll_rst_o(pll_rst_o), .div_wr_o(div_wr_o),
        .ref_div_o(ref_div_o), .out_div_o(out_div_o), .fb_div_o(fb_div_o), .bw_div_o(bw_div_o),
        .lock_i(lock_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) wd_hit <= 1'b1;
        if (preset_en) begin
            m_ref  <= REF_W'(p_ref);
            m_out  <= OUT_W'(p_out);
            m_fb   <= FB_W'(p_fb);
            m_bw   <= BW_W'(p_bw);
            m_mode <= 2'(p_mode);
        end else begin
            if (div_wr_o) begin
                m_ref <= ref_div_o; m_out <= out_div_o; m_fb <= fb_div_o; m_bw <= bw_div_o;
            end
            if (mode_wr_o) m_mode <= mode_sel_o;
        end
        if (div_wr_o) since_wr <= 1;
        else if (since_wr < 1000000) since_wr <= since_wr + 1;
    end

    always @(negedge clk) begin
        if (div_wr_o && nw < 4) begin
            wr_cyc[nw] = cyc; wr_ref[nw] = ref_div_o; wr_out[nw] = out_div_o;
            wr_fb[nw] = fb_div_o; wr_bw[nw] = bw_div_o; wr_rst[nw] = pll_rst_o;
            nw = nw + 1;
        end
        if (mode_wr_o && nm < 4) begin
            mw_cyc[nm] = cyc; mw_val[nm] = int'(mode_sel_o); nm = nm + 1;
        end
        if (pll_rst_o && !prev_rst && nrr < 4) begin rr_cyc[nrr] = cyc; nrr = nrr + 1; end
        if (!pll_rst_o && prev_rst && nrf < 4) begin rf_cyc[nrf] = cyc; nrf = nrf + 1; end
        if (done_o) begin nd = nd + 1; d_cyc = cyc; d_err = err_o; end
        if (done_o && prev_done) dw_bad = 1'b1;
        prev_rst = pll_rst_o;
        prev_done = done_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int settle_c(input int r);
        return ((r * 500) / 24 + 1) * CPU;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run_txn(input int nref, input int nout, input int nfb, input int nbw,
                           input int oref, input int oout, input int ofb, input int obw,
                           input int pmode, input int latv, input bit extra, input bit hold_chk);
        int c0, n1, n2, w2x, dx, exp_nw, wait_n;
        bit ok1, ok2, exp_err;
        @(negedge clk);
        p_ref = oref; p_out = oout; p_fb = ofb; p_bw = obw; p_mode = pmode;
        preset_en = 1'b1; lat = latv;
        @(negedge clk);
        preset_en = 1'b0;
        if (hold_chk) chk(err_o == 1'b1, "R8 error held while idle", int'(err_o), 1);
        nw = 0; nm = 0; nd = 0; nrr = 0; nrf = 0; dw_bad = 1'b0;
        start_i = 1'b1;
        ref_div_i = REF_W'(nref); out_div_i = OUT_W'(nout); fb_div_i = FB_W'(nfb); bw_div_i = BW_W'(nbw);
        c0 = cyc;
        @(negedge clk);
        start_i = 1'b0;
        ref_div_i = REF_W'($urandom); out_div_i = OUT_W'($urandom);
        fb_div_i = FB_W'($urandom); bw_div_i = BW_W'($urandom);
        chk(err_o == 1'b0, "R8 error cleared after start", int'(err_o), 0);
        if (extra) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_n = 0;
        while (nd == 0 && !wd_hit) begin @(negedge clk); wait_n = wait_n + 1; end
        repeat (6) @(negedge clk);
        // expected values
        n1 = settle_c(nref);
        ok1 = (nfb != 0) && (latv <= n1 + POLLS);
        n2 = settle_c(oref);
        ok2 = (ofb != 0) && (latv <= n2 + POLLS);
        exp_nw = ok1 ? 1 : 2;
        exp_err = !ok1;
        chk(nw == exp_nw, ok1 ? "R9 single write on lock" : "R12 write count with write-back", nw, exp_nw);
        chk(nd == 1, "R2 one done per accepted start", nd, 1);
        chk(!dw_bad, "R11 done one cycle", int'(dw_bad), 0);
        if (nw >= 1) begin
            chk(wr_cyc[0] == c0 + 3, "R2 first write three cycles after start", wr_cyc[0], c0 + 3);
            chk(wr_ref[0] == REF_W'(nref) && wr_fb[0] == FB_W'(nfb) &&
                wr_out[0] == OUT_W'(nout) && wr_bw[0] == BW_W'(nbw),
                "R10 requested ratios written", int'(wr_fb[0]), nfb);
            chk(wr_rst[0], "R4 reset high during write", int'(wr_rst[0]), 1);
            chk(nrr >= 1 && rr_cyc[0] == wr_cyc[0] - 1, "R4 reset rises before write", rr_cyc[0], wr_cyc[0] - 1);
            chk(nrf >= 1 && rf_cyc[0] == wr_cyc[0] + 1, "R4 reset falls after write", rf_cyc[0], wr_cyc[0] + 1);
            if (ok1) begin
                dx = wr_cyc[0] + imax(n1 + 1, latv) + 2;
                chk(d_cyc == dx, "R5 R6 done timing after lock", d_cyc, dx);
            end
        end
        if (!ok1 && nw >= 2) begin
            w2x = wr_cyc[0] + n1 + POLLS + 2;
            chk(wr_cyc[1] == w2x, "R7 write-back timing", wr_cyc[1], w2x);
            chk(wr_ref[1] == REF_W'(oref) && wr_fb[1] == FB_W'(ofb) &&
                wr_out[1] == OUT_W'(oout) && wr_bw[1] == BW_W'(obw),
                "R7 prior ratios written back", int'(wr_fb[1]), ofb);
            dx = ok2 ? wr_cyc[1] + imax(n2 + 1, latv) + 2 : wr_cyc[1] + n2 + POLLS + 2;
            chk(d_cyc == dx, ok2 ? "R7 done after write-back lock" : "R12 done after second timeout", d_cyc, dx);
        end
        chk(d_err == exp_err, exp_err ? "R7 error at done" : "R6 no error at done", int'(d_err), int'(exp_err));
        chk(err_o == exp_err, "R8 error after done", int'(err_o), int'(exp_err));
        if (pmode == 1) begin
            chk(nm == 2, "R3 two mux writes from normal", nm, 2);
            chk(mw_val[0] == 0 && mw_cyc[0] < wr_cyc[0], "R3 slow before write", mw_val[0], 0);
            chk(mw_val[1] == 1 && mw_cyc[1] == d_cyc - 1, "R3 normal before done", mw_cyc[1], d_cyc - 1);
        end else begin
            chk(nm == 0, "R3 no mux write when not normal", nm, 0);
        end
    endtask

    initial begin
        int seedv, r, f, m, l, orf, ofv;
        seedv = $urandom(32'd2024);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !err_o && !div_wr_o && !mode_wr_o && !pll_rst_o,
            "R1 outputs low in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !err_o && !div_wr_o && !mode_wr_o && !pll_rst_o,
            "R1 outputs low after reset", int'(busy_o), 0);

        // normal mode, immediate lock
        run_txn(2, 3, 100, 7, 1, 1, 50, 2, 1, 0, 1'b0, 1'b0);
        // slow mode, lock arrives after settle
        run_txn(3, 1, 200, 9, 2, 2, 60, 3, 0, 200, 1'b0, 1'b0);
        // deep-slow mode, extra start while busy
        run_txn(1, 2, 77, 5, 2, 2, 60, 3, 2, 10, 1'b1, 1'b0);
        // new ratios never lock, write-back locks
        run_txn(4, 1, 0, 4, 2, 3, 88, 6, 1, 5, 1'b0, 1'b0);
        // both fail, error held into next run check
        run_txn(2, 1, 0, 4, 3, 3, 0, 6, 1, 0, 1'b0, 1'b1);
        // identical settings still run the full sequence
        run_txn(5, 2, 300, 11, 5, 2, 300, 11, 1, 0, 1'b0, 1'b0);
        // largest reference ratio settle time
        run_txn(63, 4, 500, 1, 1, 1, 40, 1, 1, 0, 1'b0, 1'b0);

        for (int i = 0; i < 24 && !wd_hit; i++) begin
            r = $urandom_range(1, 10);
            orf = $urandom_range(1, 10);
            f = ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(1, 4000);
            ofv = ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(1, 4000);
            m = $urandom_range(0, 2);
            l = $urandom_range(0, settle_c(r) + POLLS + 5);
            run_txn(r, $urandom_range(0, 15), f, $urandom_range(0, 4095),
                    orf, $urandom_range(0, 15), ofv, $urandom_range(0, 4095),
                    m, l, ($urandom_range(0, 3) == 0), 1'b0);
        end

        if (wd_hit) chk(1'b0, "watchdog expired", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule